// File: doc/BRIEF.md
# Packet Receive FIFO with Group-Counted Threshold

This block buffers received packet bytes between a bit-level packet receiver and a host. Each stored entry holds one data byte plus two tags: one marking the last byte of a packet and one marking a packet judged bad by the receiver. The host drains the store one entry at a time through a first-word-fall-through read port. A data-available flag goes high once the number of stored bytes reaches a programmable level. That level is given in groups of eight bytes.

A control register holds the 5-bit level and a flush bit. While the flush bit is set, the store is held empty and the available flag is held low. Host reads and incoming bytes are both ignored. Once the flush bit is cleared, the store is usable again, but bytes are thrown away until a byte that opens a packet arrives while the storage is ready. The same hunting applies after the block's own reset. The status side has three parts: an edge-latched copy of the available flag, a sticky overflow bit, and an interrupt gated by two enable inputs.

Top module: `pkt_rx_fifo`

## Requirements
- R1: After reset the store is empty, the level is 8 groups, the flush bit is 0, and `avail`, `avail_lat`, `ovf` and `irq` are all 0.
- R2: Entries leave in arrival order. `rd_data`, `rd_eop` and `rd_bad` show the oldest entry while `rd_empty` is 0. A read with `rd_en` high removes that entry on the clock edge.
- R3: `avail` is 1 exactly when the flush bit is 0 and the stored byte count is at least level×8, with the level taken from `cfg_level[4:0]`. With the default level, 63 bytes give 0 and 64 bytes give 1. Level 0 gives 1 even when the store is empty.
- R4: While the flush bit is 1, the store is emptied on every clock, `avail` is 0, reads remove nothing, and no incoming byte is stored. `cfg_we` loads `cfg_level` and `cfg_flush` on the clock edge.
- R5: After reset, and after the flush bit returns to 0, incoming bytes are dropped until one arrives with `wr_sop` high. That byte and the bytes after it are stored.
- R6: No byte is stored in a cycle where `ram_ready` is 0.
- R7: A byte that would be stored while 256 bytes are already held is dropped and sets `ovf`. `ovf` stays set until a cycle with `clr_ovf` high; a new overflow in that same cycle wins.
- R8: `avail_lat` is set one clock after `avail` rises and stays set until a cycle with `clr_avail` high. A new rise wins over the clear.
- R9: `irq` equals (`avail_lat` AND `ie_avail`) OR (`ovf` AND `ie_ovf`).
- R10: A read and a store in the same cycle both take effect. The byte count is unchanged and order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the control register |
| cfg_level | input | 5 | New level in 8-byte groups |
| cfg_flush | input | 1 | New flush bit |
| ram_ready | input | 1 | Storage ready; stores allowed only when 1 |
| wr_valid | input | 1 | Incoming byte present |
| wr_sop | input | 1 | Incoming byte opens a packet |
| wr_eop | input | 1 | Incoming byte closes a packet |
| wr_bad | input | 1 | Incoming packet marked bad |
| wr_data | input | 8 | Incoming byte |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Oldest byte |
| rd_eop | output | 1 | Oldest byte's end-of-packet tag |
| rd_bad | output | 1 | Oldest byte's bad-packet tag |
| rd_empty | output | 1 | Store empty |
| clr_avail | input | 1 | Write-one clear of `avail_lat` |
| clr_ovf | input | 1 | Write-one clear of `ovf` |
| ie_avail | input | 1 | Interrupt enable for `avail_lat` |
| ie_ovf | input | 1 | Interrupt enable for `ovf` |
| avail | output | 1 | Data-available flag |
| avail_lat | output | 1 | Latched rise of `avail` |
| ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the threshold boundary at 63 versus 64 bytes, where a design that compares with a strict inequality or counts the level in bytes would raise `avail` one byte late or far too early. It also fills the store to 256 bytes and pushes one more. A design with a wrong full test would either wrap and overwrite the oldest byte or fail to set `ovf`. Next it releases a flush and sends bytes that do not open a packet, to catch a design that resumes storing at once. Finally it times the latched flag one clock after the rise and checks that a clear arriving together with a set leaves the bit set.

// File: rtl/prf_pkg.sv
package prf_pkg;
    localparam int DATA_W  = 8;
    localparam int GROUP   = 8;
    localparam int LVL_W   = 5;
    localparam int LVL_RST = 8;

    typedef struct packed {
        logic              eop;
        logic              bad;
        logic [DATA_W-1:0] data;
    } entry_t;

    function automatic int unsigned level_bytes(input logic [LVL_W-1:0] lvl);
        return int'(lvl) * GROUP;
    endfunction
endpackage

// File: rtl/prf_store.sv
module prf_store
    import prf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  entry_t        wentry,
    input  logic          pop,
    output entry_t        rentry,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    entry_t        mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    assign full   = (count == CW'(DEPTH));
    assign empty  = (count == '0);
    assign rentry = mem[rptr];

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wentry;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= wptr + 1'b1;
            if (pop)  rptr <= rptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end
endmodule

// File: rtl/prf_gate.sv
module prf_gate (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic wr_valid,
    input  logic wr_sop,
    input  logic ram_ready,
    output logic accept,
    output logic hunt
);
    assign accept = !flush && wr_valid && ram_ready && (!hunt || wr_sop);

    always_ff @(posedge clk) begin
        if (rst || flush) hunt <= 1'b1;
        else if (accept)  hunt <= 1'b0;
    end
endmodule

// File: rtl/prf_status.sv
module prf_status
    import prf_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [CW-1:0]    count,
    input  logic [LVL_W-1:0] level,
    input  logic             ovf_evt,
    input  logic             clr_avail,
    input  logic             clr_ovf,
    input  logic             ie_avail,
    input  logic             ie_ovf,
    output logic             avail,
    output logic             avail_lat,
    output logic             ovf,
    output logic             irq
);
    logic avail_q;

    assign avail = !flush && (int'(count) >= int'(level_bytes(level)));
    assign irq   = (avail_lat && ie_avail) || (ovf && ie_ovf);

    always_ff @(posedge clk) begin
        if (rst) begin
            avail_q   <= 1'b0;
            avail_lat <= 1'b0;
            ovf       <= 1'b0;
        end else begin
            avail_q   <= avail;
            avail_lat <= (avail && !avail_q) || (avail_lat && !clr_avail);
            ovf       <= ovf_evt || (ovf && !clr_ovf);
        end
    end
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
    import prf_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [LVL_W-1:0]  cfg_level,
    input  logic              cfg_flush,
    input  logic              ram_ready,
    input  logic              wr_valid,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic              wr_bad,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eop,
    output logic              rd_bad,
    output logic              rd_empty,
    input  logic              clr_avail,
    input  logic              clr_ovf,
    input  logic              ie_avail,
    input  logic              ie_ovf,
    output logic              avail,
    output logic              avail_lat,
    output logic              ovf,
    output logic              irq
);
    logic             flush_q;
    logic [LVL_W-1:0] level_q;
    logic             accept, hunt, full, push, pop;
    logic [CW-1:0]    count;
    entry_t           wentry, rentry;

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_q <= 1'b0;
            level_q <= LVL_W'(LVL_RST);
        end else if (cfg_we) begin
            flush_q <= cfg_flush;
            level_q <= cfg_level;
        end
    end

    assign wentry = '{eop: wr_eop, bad: wr_bad, data: wr_data};
    assign push   = accept && !full;
    assign pop    = rd_en && !rd_empty && !flush_q;

    prf_gate u_gate (
        .clk(clk), .rst(rst), .flush(flush_q), .wr_valid(wr_valid),
        .wr_sop(wr_sop), .ram_ready(ram_ready), .accept(accept), .hunt(hunt)
    );

    prf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst), .flush(flush_q), .push(push), .wentry(wentry),
        .pop(pop), .rentry(rentry), .count(count), .full(full), .empty(rd_empty)
    );

    prf_status #(.CW(CW)) u_status (
        .clk(clk), .rst(rst), .flush(flush_q), .count(count), .level(level_q),
        .ovf_evt(accept && full), .clr_avail(clr_avail), .clr_ovf(clr_ovf),
        .ie_avail(ie_avail), .ie_ovf(ie_ovf), .avail(avail),
        .avail_lat(avail_lat), .ovf(ovf), .irq(irq)
    );

    assign rd_data = rentry.data;
    assign rd_eop  = rentry.eop;
    assign rd_bad  = rentry.bad;
endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          flush_q,
    input logic          hunt,
    input logic [CW-1:0] count,
    input logic          full,
    input logic          wr_valid,
    input logic          wr_sop,
    input logic          ram_ready,
    input logic          avail,
    input logic          avail_lat,
    input logic          clr_avail,
    input logic          ovf,
    input logic          rd_empty
);
    a_r4_flush_avail_low: assert property (@(posedge clk) disable iff (rst)
        flush_q |-> !avail);

    a_r4_flush_empties: assert property (@(posedge clk) disable iff (rst)
        $past(flush_q) |-> rd_empty);

    a_r3_full_is_avail: assert property (@(posedge clk) disable iff (rst)
        (!flush_q && full) |-> avail);

    a_r5_hunt_drops: assert property (@(posedge clk) disable iff (rst)
        (hunt && wr_valid && !wr_sop && !flush_q) |=> (count <= $past(count)));

    a_r6_not_ready_no_store: assert property (@(posedge clk) disable iff (rst)
        !ram_ready |=> (count <= $past(count)));

    a_r7_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        $past(full && wr_valid && ram_ready && !flush_q && !hunt) |-> ovf);

    a_r8_rise_latches: assert property (@(posedge clk) disable iff (rst)
        ($rose(avail) && !clr_avail) |=> avail_lat);
endmodule

bind pkt_rx_fifo prf_checker #(.CW(CW)) u_prf_checker (
    .clk(clk), .rst(rst), .flush_q(flush_q), .hunt(hunt), .count(count),
    .full(full), .wr_valid(wr_valid), .wr_sop(wr_sop), .ram_ready(ram_ready),
    .avail(avail), .avail_lat(avail_lat), .clr_avail(clr_avail), .ovf(ovf),
    .rd_empty(rd_empty)
);

// File: tb/test_pkt_rx_fifo.sv
module test_pkt_rx_fifo;
    logic clk = 1'b0, rst = 1'b1;
    logic cfg_we = 0, cfg_flush = 0, ram_ready = 1, wr_valid = 0, wr_sop = 0;
    logic wr_eop = 0, wr_bad = 0, rd_en = 0, clr_avail = 0, clr_ovf = 0;
    logic ie_avail = 0, ie_ovf = 0;
    logic [4:0] cfg_level = 5'd8;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic rd_eop, rd_bad, rd_empty, avail, avail_lat, ovf, irq;

    always #10 clk = ~clk;

    pkt_rx_fifo i_pkt_rx_fifo (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [9:0] mq[$];
    bit m_flush = 0, m_hunt = 1, m_lat = 0, m_ovf = 0, m_prev = 0;
    int m_level = 8;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit m_avail();
        return !m_flush && (mq.size() >= m_level * 8);
    endfunction

    task automatic model_step();
        bit cur, acc, full, pop, n_ovf, n_lat;
        cur  = m_avail();
        full = (mq.size() == 256);
        acc  = !m_flush && wr_valid && ram_ready && (!m_hunt || wr_sop);
        pop  = rd_en && mq.size() > 0 && !m_flush;
        n_ovf = (acc && full) || (m_ovf && !clr_ovf);
        n_lat = (cur && !m_prev) || (m_lat && !clr_avail);
        if (m_flush) mq.delete();
        else begin
            if (pop) void'(mq.pop_front());
            if (acc && !full) mq.push_back({wr_eop, wr_bad, wr_data});
        end
        if (m_flush) m_hunt = 1;
        else if (acc) m_hunt = 0;
        m_ovf = n_ovf; m_lat = n_lat; m_prev = cur;
        if (cfg_we) begin m_flush = cfg_flush; m_level = cfg_level; end
    endtask

    task automatic compare_all();
        bit mirq;
        mirq = (m_lat && ie_avail) || (m_ovf && ie_ovf);
        check(rd_empty == (mq.size() == 0), "R2 empty", rd_empty, mq.size() == 0);
        if (mq.size() > 0)
            check({rd_eop, rd_bad, rd_data} == mq[0], "R2 head entry",
                  {rd_eop, rd_bad, rd_data}, mq[0]);
        check(avail == m_avail(), "R3 avail", avail, m_avail());
        check(avail_lat == m_lat, "R8 avail_lat", avail_lat, m_lat);
        check(ovf == m_ovf, "R7 ovf", ovf, m_ovf);
        check(irq == mirq, "R9 irq", irq, mirq);
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        cfg_we = 0; wr_valid = 0; wr_sop = 0; wr_eop = 0; wr_bad = 0;
        rd_en = 0; clr_avail = 0; clr_ovf = 0; ram_ready = 1;
    endtask

    task automatic put(input bit sop, input bit eop, input logic [7:0] d, input bit rd);
        idle(); wr_valid = 1; wr_sop = sop; wr_eop = eop; wr_data = d; rd_en = rd;
        cyc();
    endtask

    task automatic setcfg(input int lvl, input bit fl);
        idle(); cfg_we = 1; cfg_level = 5'(lvl); cfg_flush = fl;
        cyc();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(rd_empty && !avail && !avail_lat && !ovf && !irq, "R1 reset state",
              {rd_empty, avail, avail_lat, ovf, irq}, 5'b10000);
        compare_all();
        // R5 hunting after reset
        put(0, 0, 8'h11, 0);
        check(rd_empty == 1, "R5 non-start byte dropped", rd_empty, 1);
        // R6 storage not ready
        idle(); wr_valid = 1; wr_sop = 1; wr_data = 8'h22; ram_ready = 0; cyc();
        check(rd_empty == 1, "R6 byte dropped while not ready", rd_empty, 1);
        put(1, 0, 8'h33, 0);
        check(rd_empty == 0 && rd_data == 8'h33, "R5 start byte stored", rd_data, 8'h33);
        // R10 simultaneous read and store
        put(0, 1, 8'h44, 1);
        check(rd_empty == 0 && rd_data == 8'h44 && rd_eop == 1, "R10 read+store",
              rd_data, 8'h44);
        // R4 flush and release, R3 threshold at default level
        setcfg(8, 1);
        idle(); rd_en = 1; wr_valid = 1; wr_sop = 1; cyc();
        check(rd_empty == 1 && avail == 0, "R4 flush empties and drops", rd_empty, 1);
        setcfg(8, 0);
        put(0, 0, 8'h01, 0);
        check(rd_empty == 1, "R5 dropped after flush release", rd_empty, 1);
        put(1, 0, 8'h00, 0);
        for (int i = 1; i < 63; i++) put(0, 0, 8'(i), 0);
        check(avail == 0, "R3 63 bytes not available", avail, 0);
        put(0, 0, 8'hAA, 0);
        check(avail == 1, "R3 64 bytes available", avail, 1);
        idle(); ie_avail = 1; clr_avail = 1; cyc();
        check(avail_lat == 1, "R8 set wins over clear one clock after rise", avail_lat, 1);
        check(irq == 1, "R9 irq from latched flag", irq, 1);
        idle(); clr_avail = 1; cyc();
        check(avail_lat == 0, "R8 write-one clear", avail_lat, 0);
        // R7 overflow
        for (int i = 64; i < 256; i++) put(0, 0, 8'(i), 0);
        put(0, 0, 8'hEE, 0);
        check(ovf == 1, "R7 overflow sets flag", ovf, 1);
        check(rd_data == 8'h00, "R7 oldest byte kept", rd_data, 0);
        idle(); ie_ovf = 1; ie_avail = 0; cyc();
        check(irq == 1, "R9 irq from overflow", irq, 1);
        idle(); clr_ovf = 1; cyc();
        check(ovf == 0, "R7 write-one clear", ovf, 0);
        // R3 level extremes
        setcfg(31, 0);
        check(avail == 1, "R3 level 31 with 256 bytes", avail, 1);
        setcfg(0, 1);
        setcfg(0, 0);
        check(avail == 1, "R3 level 0 on empty store", avail, 1);

        // constrained random phases
        for (int ph = 0; ph < 24; ph++) begin
            int pw, pr;
            pw = 20 + $urandom_range(0, 75);
            pr = 20 + $urandom_range(0, 75);
            ie_avail = $urandom_range(0, 1);
            ie_ovf   = $urandom_range(0, 1);
            for (int c = 0; c < 400; c++) begin
                idle();
                wr_valid  = ($urandom_range(0, 99) < pw);
                wr_sop    = ($urandom_range(0, 15) == 0);
                wr_eop    = ($urandom_range(0, 15) == 0);
                wr_bad    = ($urandom_range(0, 31) == 0);
                wr_data   = 8'($urandom);
                rd_en     = ($urandom_range(0, 99) < pr);
                ram_ready = ($urandom_range(0, 19) != 0);
                clr_avail = ($urandom_range(0, 7) == 0);
                clr_ovf   = ($urandom_range(0, 7) == 0);
                if ($urandom_range(0, 149) == 0) begin
                    cfg_we = 1;
                    cfg_level = 5'($urandom);
                    cfg_flush = ($urandom_range(0, 2) == 0);
                end else if (m_flush && $urandom_range(0, 3) == 0) begin
                    cfg_we = 1; cfg_level = 5'(m_level); cfg_flush = 0;
                end
                cyc();
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule